// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block performs one integer operation per accepted request on a 32-bit datapath. The operation is one of add, add-with-carry, subtract, increment, decrement, AND, OR or XOR, at an operand width of 8, 16 or 32 bits. Every operation returns a result and six status flags: carry, parity, auxiliary carry, zero, sign and overflow. The flags are always computed for the selected width. Flags that have no arithmetic meaning after a logical operation are given fixed values. When the second operand is a byte immediate, a control bit sign-extends it to the selected width before the operation.

The arithmetic is combinational. A one-deep output register sits between the request stream and the result stream, and both streams use valid/ready. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid` high, and it stays there, unchanged, until `out_ready` is seen high. The block takes a new request whenever the output register is empty or is being emptied in the same cycle. Back-pressure therefore passes straight from `out_ready` to `in_ready` with no extra delay and no loss of throughput.

Top module: `flag_alu`

## Requirements
- R1: `in_op` selects the operation: 0 ADD, 1 ADC, 2 SUB, 3 INC, 4 DEC, 5 AND, 6 OR, 7 XOR. `in_size` selects the width: 0 for 8 bits, 1 for 16 bits, 2 or 3 for 32 bits. Result bits above the selected width are zero.
- R2: When `in_imm8_sext` is 1, only bits 7:0 of `in_b` are used, sign-extended to the selected width. When it is 0, `in_b` is used truncated to the width.
- R3: ADD, ADC and SUB return (a+b), (a+b+`in_carry`) and (a-b) modulo 2^width. The carry flag is the unsigned carry out of the width, or the borrow for SUB.
- R4: For the five arithmetic operations, the overflow flag is set exactly when the signed result falls outside the signed range of the selected width.
- R5: The auxiliary flag is the carry (or borrow) from bit 3 into bit 4. After INC it is set exactly when the low nibble of the result is zero.
- R6: INC and DEC add or subtract one and copy `in_carry` to the carry flag.
- R7: AND, OR and XOR clear the carry, overflow and auxiliary flags.
- R8: Zero is set when the result is all zeros. Sign is the result bit at the top of the selected width. Parity is set when result bits 7:0 hold an even number of ones. `out_flags` bit positions are: 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow.
- R9: `in_ready` is high when the output register is empty or `out_ready` is high. An accepted request produces `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, the result and flags hold steady.
- R10: After reset, `out_valid` is low and `out_result` and `out_flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Operand width select |
| in_a | input | 32 | Destination operand |
| in_b | input | 32 | Source operand |
| in_imm8_sext | input | 1 | Treat source as sign-extended byte |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_result | output | 32 | Result, zero above the width |
| out_flags | output | 6 | Status flags {OF,SF,ZF,AF,PF,CF} |

## Verification
Two things can fall in the same clock edge: the consumer taking the held result and a new request being loaded into the output register. Random `out_ready` throttling is combined with a mostly-high `in_valid`, so cycles where both handshakes happen together are common. Results go into an ordered scoreboard when a request is accepted and are compared when they are taken. A lost, duplicated or early-overwritten result therefore shows up as a mismatch or an ordering error, and `in_ready` is compared every cycle against the state of the output stream.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW    = 32;
  localparam int OPW   = 3;
  localparam int SZW   = 2;
  localparam int NFLAG = 6;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } alu_op_e;

  // bit 0 is carry, bit 5 is overflow
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } alu_flags_t;

  function automatic int unsigned msb_of(input logic [SZW-1:0] sz);
    case (sz)
      2'd0:    return 7;
      2'd1:    return 15;
      default: return DW - 1;
    endcase
  endfunction

  function automatic logic is_logic_op(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [SZW-1:0] size,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           imm8_sext,
  output logic [W-1:0]   mask,
  output logic [W-1:0]   a_m,
  output logic [W-1:0]   b_m
);
  localparam int IMMW = 8;
  logic [W-1:0] b_ext;

  always_comb begin
    case (size)
      2'd0:    mask = W'((64'd1 << 8) - 64'd1);
      2'd1:    mask = W'((64'd1 << 16) - 64'd1);
      default: mask = '1;
    endcase
  end

  assign b_ext = imm8_sext ? {{(W-IMMW){b[IMMW-1]}}, b[IMMW-1:0]} : b;
  assign a_m   = a & mask;
  assign b_m   = b_ext & mask;
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = DW
) (
  input  alu_op_e        op,
  input  logic [SZW-1:0] size,
  input  logic [W-1:0]   mask,
  input  logic [W-1:0]   a_m,
  input  logic [W-1:0]   b_m,
  input  logic           carry_in,
  output logic [W-1:0]   res,
  output logic           cout,
  output logic           aux,
  output logic           ovf
);
  logic [W-1:0] opnd;
  logic         do_sub;
  logic         cin;
  logic [W:0]   sum;
  logic         sa, sb, sr;
  int unsigned  top;

  always_comb begin
    opnd   = b_m;
    do_sub = 1'b0;
    cin    = 1'b0;
    case (op)
      OP_ADC: cin = carry_in;
      OP_SUB: do_sub = 1'b1;
      OP_INC: opnd = W'(1);
      OP_DEC: begin opnd = W'(1); do_sub = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    if (do_sub) sum = {1'b0, a_m} - {1'b0, opnd};
    else        sum = {1'b0, a_m} + {1'b0, opnd} + {{W{1'b0}}, cin};
  end

  assign top = msb_of(size);

  always_comb begin
    case (op)
      OP_AND:  res = a_m & b_m;
      OP_OR:   res = a_m | b_m;
      OP_XOR:  res = a_m ^ b_m;
      default: res = sum[W-1:0] & mask;
    endcase
  end

  // carry out of the selected width sits one bit above its MSB
  always_comb begin
    case (size)
      2'd0:    cout = sum[8];
      2'd1:    cout = sum[16];
      default: cout = sum[W];
    endcase
  end

  assign aux = a_m[4] ^ opnd[4] ^ sum[4];
  assign sa  = a_m[top];
  assign sb  = opnd[top];
  assign sr  = sum[top];
  assign ovf = do_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
#(
  parameter int W = DW
) (
  input  alu_op_e        op,
  input  logic [SZW-1:0] size,
  input  logic [W-1:0]   res,
  input  logic           cout,
  input  logic           aux,
  input  logic           ovf,
  input  logic           carry_in,
  output alu_flags_t     flags
);
  logic logic_op;
  logic step_op;

  assign logic_op = is_logic_op(op);
  assign step_op  = (op == OP_INC) || (op == OP_DEC);

  always_comb begin
    flags.zro = (res == '0);
    flags.sgn = res[msb_of(size)];
    flags.par = ~^res[7:0];
    flags.cry = logic_op ? 1'b0 : (step_op ? carry_in : cout);
    flags.aux = logic_op ? 1'b0 : aux;
    flags.ovf = logic_op ? 1'b0 : ovf;
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [1:0]    in_size,
  input  logic [31:0]   in_a,
  input  logic [31:0]   in_b,
  input  logic          in_imm8_sext,
  input  logic          in_carry,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_result,
  output logic [5:0]    out_flags
);
  alu_op_e      op;
  logic [DW-1:0] mask, a_m, b_m, res;
  logic          cout, aux, ovf;
  alu_flags_t    flags;
  logic          accept;

  logic          vld_q;
  logic [DW-1:0] res_q;
  alu_flags_t    flg_q;

  assign op = alu_op_e'(in_op);

  alu_operand_prep #(.W(DW)) u_prep (
    .size(in_size), .a(in_a), .b(in_b), .imm8_sext(in_imm8_sext),
    .mask(mask), .a_m(a_m), .b_m(b_m)
  );

  alu_datapath #(.W(DW)) u_dp (
    .op(op), .size(in_size), .mask(mask), .a_m(a_m), .b_m(b_m),
    .carry_in(in_carry), .res(res), .cout(cout), .aux(aux), .ovf(ovf)
  );

  alu_flag_gen #(.W(DW)) u_flags (
    .op(op), .size(in_size), .res(res), .cout(cout), .aux(aux),
    .ovf(ovf), .carry_in(in_carry), .flags(flags)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      res_q <= res;
      flg_q <= flags;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_flags  = flg_q;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [2:0]  in_op,
  input logic [1:0]  in_size,
  input logic        in_carry,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_result,
  input logic [5:0]  out_flags
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_size == 2'd0) |=> (out_result[31:8] == 24'd0));

  p_step_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op == 3'd3 || in_op == 3'd4)) |=> (out_flags[0] == $past(in_carry)));

  p_logic_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op >= 3'd5) |=> (out_flags[0] == 1'b0 && out_flags[2] == 1'b0 && out_flags[5] == 1'b0));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[3] == (out_result == 32'd0)));

  p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[1] == ~^out_result[7:0]));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind flag_alu flag_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_size(in_size), .in_carry(in_carry),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_flags(out_flags)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        in_imm8_sext = 1'b0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic [5:0]  out_flags;

  int n_chk = 0;
  int n_fail = 0;
  logic [37:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_a(in_a), .in_b(in_b),
    .in_imm8_sext(in_imm8_sext), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  // returns {OF,SF,ZF,AF,PF,CF,result}
  function automatic logic [37:0] model(input logic [2:0] op, input logic [1:0] sz,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic sx, input logic cin);
    int w;
    longint unsigned mask, ua, ub, r;
    longint sa, sb, sr, smax, smin;
    logic cf, af, of, zf, sf, pf;
    logic [31:0] bb, res;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mask = (64'd1 << w) - 64'd1;
    bb   = sx ? {{24{b[7]}}, b[7:0]} : b;
    ua   = {32'd0, a} & mask;
    ub   = {32'd0, bb} & mask;
    if (op == 3'd3 || op == 3'd4) ub = 1;
    sa = longint'(ua); if (ua[w-1]) sa = sa - (longint'(1) << w);
    sb = longint'(ub); if (ub[w-1]) sb = sb - (longint'(1) << w);
    smax = (longint'(1) << (w-1)) - 1;
    smin = -(longint'(1) << (w-1));
    cf = 0; af = 0; of = 0; r = 0;
    case (op)
      3'd0, 3'd1, 3'd3: begin
        r  = ua + ub + ((op == 3'd1) ? {63'd0, cin} : 64'd0);
        sr = sa + sb + ((op == 3'd1) ? longint'(cin) : 0);
        cf = (r > mask);
        af = ((ua & 15) + (ub & 15) + ((op == 3'd1) ? {63'd0, cin} : 64'd0)) > 15;
        of = (sr > smax) || (sr < smin);
      end
      3'd2, 3'd4: begin
        r  = ua - ub;
        sr = sa - sb;
        cf = (ua < ub);
        af = (ua & 15) < (ub & 15);
        of = (sr > smax) || (sr < smin);
      end
      3'd5: r = ua & ub;
      3'd6: r = ua | ub;
      default: r = ua ^ ub;
    endcase
    if (op == 3'd3 || op == 3'd4) cf = cin;
    res = 32'(r & mask);
    zf  = (res == 32'd0);
    sf  = res[w-1];
    pf  = ~^res[7:0];
    return {of, sf, zf, af, pf, cf, res};
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    if (op <= 3'd2) return "R3";
    if (op <= 3'd4) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, judge the coming rising edge
  task automatic step(input logic iv, input logic [2:0] op, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] b, input logic sx,
                      input logic cin, input logic ordy, input string tag);
    @(negedge clk);
    in_valid = iv; in_op = op; in_size = sz; in_a = a; in_b = b;
    in_imm8_sext = sx; in_carry = cin; out_ready = ordy;
    #1;
    check("R9 in_ready", {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected output", 64'd1, 64'd0);
      end else begin
        check(tag_q[0], {26'd0, out_flags, out_result}, {26'd0, exp_q[0]});
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
    if (iv && in_ready) begin
      exp_q.push_back(model(op, sz, a, b, sx, cin));
      tag_q.push_back(tag);
    end
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10: state after reset
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 out_result", {32'd0, out_result}, 64'd0);
    check("R10 out_flags", {58'd0, out_flags}, 64'd0);
    rst_n = 1'b1;

    // directed corners
    step(1, 3'd0, 2'd0, 32'h7F, 32'h01, 0, 0, 1, "R4 add8 signed overflow");
    step(1, 3'd0, 2'd0, 32'hFF, 32'h01, 0, 0, 1, "R3 add8 carry wrap");
    step(1, 3'd2, 2'd1, 32'h0, 32'h1, 0, 0, 1, "R3 sub16 borrow");
    step(1, 3'd2, 2'd2, 32'h80000000, 32'h1, 0, 0, 1, "R4 sub32 overflow");
    step(1, 3'd1, 2'd2, 32'hFFFFFFFF, 32'h0, 0, 1, 1, "R3 adc32 carry-in wrap");
    step(1, 3'd0, 2'd1, 32'h0010, 32'hABCD00FE, 1, 0, 1, "R2 imm8 sext add16");
    step(1, 3'd6, 2'd2, 32'h0, 32'h80, 1, 0, 1, "R2 imm8 sext or32");
    step(1, 3'd3, 2'd0, 32'h0F, 32'h0, 0, 1, 1, "R5 inc nibble rollover");
    step(1, 3'd4, 2'd0, 32'h80, 32'h0, 0, 1, 1, "R6 dec keeps carry");
    step(1, 3'd7, 2'd2, 32'h1234ABCD, 32'h1234ABCD, 0, 1, 1, "R8 xor to zero");
    step(1, 3'd5, 2'd3, 32'hF0F0F0F0, 32'hFFFF0000, 0, 1, 1, "R1 size 3 as 32");
    step(1, 3'd0, 2'd0, 32'hFFFFFF08, 32'hFFFFFF08, 0, 0, 1, "R1 upper bits zeroed");
    step(1, 3'd2, 2'd0, 32'h10, 32'h01, 0, 0, 1, "R5 sub nibble borrow");
    step(1, 3'd0, 2'd1, 32'h00FF, 32'h0002, 0, 0, 1, "R8 parity and sign16");

    // back-pressure: hold the result, then release in the same cycle as a new request
    step(1, 3'd0, 2'd0, 32'h1, 32'h2, 0, 0, 0, "R9 held result");
    step(1, 3'd0, 2'd0, 32'h3, 32'h4, 0, 0, 0, "R9 blocked request");
    step(1, 3'd0, 2'd0, 32'h5, 32'h6, 0, 0, 1, "R9 swap same cycle");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      logic [1:0] sz;
      logic [31:0] a, b;
      op = 3'($urandom_range(0, 7));
      sz = 2'($urandom_range(0, 3));
      a  = $urandom();
      b  = $urandom();
      case ($urandom_range(0, 7))
        0: a = 32'hFFFFFFFF;
        1: b = 32'h0;
        2: a = 32'h7FFF7F7F;
        3: b = 32'h80008080;
        default: ;
      endcase
      step(($urandom_range(0, 9) != 0), op, sz, a, b, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0), op_tag(op));
    end

    for (int i = 0; i < 4; i++)
      step(0, 3'd0, 2'd0, 32'h0, 32'h0, 0, 0, 1, "R9 drain");
    check("R9 scoreboard empty", {32'd0, 32'(exp_q.size())}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule